// File: doc/BRIEF.md
# Record Hand-Off Sequencer

This block hands a finished record from a device to host memory in a fixed order. It first writes the whole record as one 64-byte burst. It then writes a 4-byte doorbell word to a separate host address. Only after that does it raise a level interrupt. Every transaction it issues has the no-snoop and relaxed-ordering attributes cleared, so a host bridge that obeys ordering rules must make the record visible before the doorbell.

An optional verify mode adds a step between the record write and the doorbell. The block reads the same 64 bytes back and waits for a split completion. It compares the returned data with what it wrote, which both pushes the record into host memory and checks it. If the completion is stale, or does not arrive within a bounded time, the block stops in an error state. It sends no doorbell and no interrupt.

The block takes a record on a valid/ready input. It drives a simple transaction-request port: `req_ready` grants the request and `req_done` reports that a write has finished on the port. Read data comes back on a completion input.

Top module: `rec_post_seq`

## Requirements
- R1: After a record is accepted, the first request is a block write (`req_type`=1) of length 64 to the record address, carrying the 512-bit record on `req_data`.
- R2: With `cfg_plain_wr`=1 at record acceptance, the record write and the doorbell write use the plain memory-write type (`req_type`=0) instead of block write.
- R3: The doorbell request is issued only after `req_done` for the record write (or after the verify step). It is a write of length 4 to the doorbell address, with the doorbell value in `req_data[31:0]` and zeros above bit 31.
- R4: `irq` rises on the clock edge that samples `req_done` for the doorbell write. It stays high until an `irq_clr` pulse clears it.
- R5: `rec_ready` is high only when the block is idle and no interrupt is pending, so records offered while busy or while `irq` is high are not taken.
- R6: `req_ns` and `req_ro` are zero on every request.
- R7: While `req_valid` is high and `req_ready` is low, the request stays valid and its type, address, length and data hold their values.
- R8: With `cfg_verify`=1 at acceptance, after the record write is done the block issues a block read (`req_type`=2) of length 64 to the record address. It makes no further request until the completion arrives.
- R9: A completion whose data differs from the written record sets the sticky `err_stale`. After that the block issues no request, raises no interrupt and takes no record until reset.
- R10: If no completion arrives within TIMEOUT cycles of the read grant, `err_timeout` is set with the same stopping behaviour as R9. A completion in the TIMEOUT-th cycle is still accepted.
- R11: `cpl_valid` has no effect unless a read-back is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_verify | input | 1 | Enable read-back verify step |
| cfg_plain_wr | input | 1 | Use plain memory-write type for writes |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record accepted when high with rec_valid |
| rec_addr | input | AW | Host address of the record |
| rec_data | input | DW | Record contents (64 bytes) |
| db_addr | input | AW | Host address of the doorbell word |
| db_value | input | 32 | Doorbell word |
| req_valid | output | 1 | Request pending |
| req_ready | input | 1 | Request granted |
| req_type | output | 2 | 0 memory write, 1 block write, 2 block read |
| req_addr | output | AW | Request address |
| req_len | output | 8 | Request length in bytes |
| req_ns | output | 1 | No-snoop attribute |
| req_ro | output | 1 | Relaxed-ordering attribute |
| req_data | output | DW | Write data |
| req_done | input | 1 | Granted write finished on the port |
| cpl_valid | input | 1 | Split completion present |
| cpl_data | input | DW | Split completion data |
| irq | output | 1 | Level interrupt |
| irq_clr | input | 1 | Interrupt clear pulse |
| err_stale | output | 1 | Sticky: read-back mismatched |
| err_timeout | output | 1 | Sticky: read-back timed out |

## Verification
The assertions check several rules on every cycle. The ordering attributes must be zero, and a stalled request must hold steady. The interrupt may rise only right after a done pulse, and no record is taken while the interrupt is pending. The error flags must stay set and silence the request port. The bench scenarios are needed for the rest. They show that the transactions come in the right order, with the right addresses, types and payloads, in each mode. They show that a stale completion blocks the doorbell, and that a completion in the last allowed cycle of the timeout window is still accepted.

// File: rtl/rec_post_seq.sv
module rec_post_seq #(
  parameter int AW      = 48,
  parameter int DW      = 512,
  parameter int TIMEOUT = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_verify,
  input  logic          cfg_plain_wr,
  input  logic          rec_valid,
  output logic          rec_ready,
  input  logic [AW-1:0] rec_addr,
  input  logic [DW-1:0] rec_data,
  input  logic [AW-1:0] db_addr,
  input  logic [31:0]   db_value,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [1:0]    req_type,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_len,
  output logic          req_ns,
  output logic          req_ro,
  output logic [DW-1:0] req_data,
  input  logic          req_done,
  input  logic          cpl_valid,
  input  logic [DW-1:0] cpl_data,
  output logic          irq,
  input  logic          irq_clr,
  output logic          err_stale,
  output logic          err_timeout
);
  localparam logic [7:0] REC_BYTES = 8'(DW / 8);
  localparam logic [7:0] DB_BYTES  = 8'd4;
  localparam logic [1:0] T_MWR = 2'd0;
  localparam logic [1:0] T_BWR = 2'd1;
  localparam logic [1:0] T_BRD = 2'd2;
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_WR_WT, S_RD, S_CPL, S_DB, S_DB_WT, S_ERR
  } st_t;

  st_t           st;
  logic [AW-1:0] r_addr, r_db_addr;
  logic [DW-1:0] r_data;
  logic [31:0]   r_db_val;
  logic          r_verify, r_plain;
  logic [CW-1:0] cnt;
  logic          irq_q, stale_q, to_q;

  assign rec_ready = (st == S_IDLE) && !irq_q;
  assign req_valid = (st == S_WR) || (st == S_RD) || (st == S_DB);
  assign req_type  = (st == S_RD) ? T_BRD : (r_plain ? T_MWR : T_BWR);
  assign req_addr  = (st == S_DB) ? r_db_addr : r_addr;
  assign req_len   = (st == S_DB) ? DB_BYTES : REC_BYTES;
  assign req_data  = (st == S_DB) ? DW'(r_db_val) : (st == S_WR) ? r_data : '0;
  assign req_ns    = 1'b0;
  assign req_ro    = 1'b0;
  assign irq         = irq_q;
  assign err_stale   = stale_q;
  assign err_timeout = to_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      r_addr    <= '0;
      r_db_addr <= '0;
      r_data    <= '0;
      r_db_val  <= '0;
      r_verify  <= 1'b0;
      r_plain   <= 1'b0;
      cnt       <= '0;
      irq_q     <= 1'b0;
      stale_q   <= 1'b0;
      to_q      <= 1'b0;
    end else begin
      if (irq_clr) irq_q <= 1'b0;
      unique case (st)
        S_IDLE: if (rec_valid && rec_ready) begin
          r_addr    <= rec_addr;
          r_data    <= rec_data;
          r_db_addr <= db_addr;
          r_db_val  <= db_value;
          r_verify  <= cfg_verify;
          r_plain   <= cfg_plain_wr;
          st        <= S_WR;
        end
        S_WR:    if (req_ready) st <= S_WR_WT;
        S_WR_WT: if (req_done) st <= r_verify ? S_RD : S_DB;
        S_RD: if (req_ready) begin
          cnt <= '0;
          st  <= S_CPL;
        end
        S_CPL: begin
          if (cpl_valid) begin
            if (cpl_data == r_data) st <= S_DB;
            else begin
              stale_q <= 1'b1;
              st      <= S_ERR;
            end
          end else if (cnt == CNT_LAST) begin
            to_q <= 1'b1;
            st   <= S_ERR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DB:    if (req_ready) st <= S_DB_WT;
        S_DB_WT: if (req_done) begin
          irq_q <= 1'b1;
          st    <= S_IDLE;
        end
        S_ERR:   st <= S_ERR;
        default: st <= S_ERR;
      endcase
    end
  end
endmodule

// File: rtl/rec_post_seq_chk.sv
module rec_post_seq_chk #(
  parameter int AW = 48,
  parameter int DW = 512
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_type,
  input logic [AW-1:0] req_addr,
  input logic [7:0]    req_len,
  input logic          req_ns,
  input logic          req_ro,
  input logic [DW-1:0] req_data,
  input logic          req_done,
  input logic          irq,
  input logic          err_stale,
  input logic          err_timeout
);
  assert_attr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (!req_ns && !req_ro));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_type) && $stable(req_addr)
                                   && $stable(req_len) && $stable(req_data)));

  assert_db_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len == 8'd4) |-> (req_data[DW-1:32] == '0));

  assert_read_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == 2'd2) |-> (req_len == 8'(DW / 8)));

  assert_irq_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(req_done));

  assert_no_take_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !rec_ready);

  assert_stale_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_stale |=> (err_stale && !req_valid && !rec_ready && !irq));

  assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> (err_timeout && !req_valid && !rec_ready && !irq));
endmodule

bind rec_post_seq rec_post_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rec_ready(rec_ready), .req_valid(req_valid),
  .req_ready(req_ready), .req_type(req_type), .req_addr(req_addr),
  .req_len(req_len), .req_ns(req_ns), .req_ro(req_ro), .req_data(req_data),
  .req_done(req_done), .irq(irq), .err_stale(err_stale), .err_timeout(err_timeout)
);

// File: tb/rec_post_seq_tb_top.sv
module rec_post_seq_tb_top;
  localparam int AW = 48;
  localparam int DW = 512;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_verify = 1'b0, cfg_plain_wr = 1'b0;
  logic rec_valid = 1'b0, rec_ready;
  logic [AW-1:0] rec_addr = '0, db_addr = '0;
  logic [DW-1:0] rec_data = '0;
  logic [31:0] db_value = '0;
  logic req_valid, req_ready = 1'b0;
  logic [1:0] req_type;
  logic [AW-1:0] req_addr;
  logic [7:0] req_len;
  logic req_ns, req_ro;
  logic [DW-1:0] req_data;
  logic req_done = 1'b0, cpl_valid = 1'b0;
  logic [DW-1:0] cpl_data = '0;
  logic irq, irq_clr = 1'b0, err_stale, err_timeout;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rec_post_seq #(.AW(AW), .DW(DW), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_verify(cfg_verify), .cfg_plain_wr(cfg_plain_wr),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_addr(rec_addr),
    .rec_data(rec_data), .db_addr(db_addr), .db_value(db_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_addr(req_addr), .req_len(req_len), .req_ns(req_ns), .req_ro(req_ro),
    .req_data(req_data), .req_done(req_done), .cpl_valid(cpl_valid),
    .cpl_data(cpl_data), .irq(irq), .irq_clr(irq_clr), .err_stale(err_stale),
    .err_timeout(err_timeout)
  );

  function automatic logic [1:0] exp_wr_type(input bit plain);
    return plain ? 2'd0 : 2'd1;
  endfunction

  function automatic logic [DW-1:0] exp_db_data(input logic [31:0] v);
    return DW'(v);
  endfunction

  function automatic logic [DW-1:0] rand_rec();
    logic [DW-1:0] d;
    for (int i = 0; i < DW / 32; i++) d[i*32 +: 32] = $urandom;
    return d;
  endfunction

  function automatic logic [AW-1:0] rand_addr(input bit align64);
    logic [AW-1:0] a;
    a = AW'({$urandom, $urandom});
    return align64 ? (a & ~AW'(63)) : (a & ~AW'(3));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_req();
    for (int i = 0; i < 200; i++) begin
      if (req_valid) break;
      @(negedge clk);
    end
    chk(req_valid, "R3/R8 request expected", 64'(req_valid), 64'd1);
  endtask

  task automatic grant(input int stall);
    logic [1:0] t; logic [AW-1:0] a; logic [7:0] l; logic [DW-1:0] d;
    t = req_type; a = req_addr; l = req_len; d = req_data;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(req_valid && req_type == t && req_addr == a && req_len == l && req_data == d,
          "R7 held request", 64'(req_addr), 64'(a));
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_ready = 1'b0; req_done = 1'b0; cpl_valid = 1'b0; rec_valid = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!irq && !req_valid && rec_ready && !err_stale && !err_timeout, "R5 reset state",
        {59'd0, irq, req_valid, rec_ready, err_stale, err_timeout}, 64'h4);
  endtask

  // mode: 0 good completion, 1 stale completion, 2 no completion
  task automatic run_record(input bit ver, input bit plain, input int mode,
                            input int cpl_k, input bit idle_cpl, output bit errored);
    logic [DW-1:0] d; logic [AW-1:0] a, da; logic [31:0] dv; string wt;
    errored = 1'b0;
    d = rand_rec(); a = rand_addr(1'b1); da = rand_addr(1'b0); dv = $urandom;
    wt = plain ? "R2" : "R1";
    cfg_verify = ver; cfg_plain_wr = plain;
    if (idle_cpl) begin
      cpl_valid = 1'b1; cpl_data = ~d;
      @(negedge clk);
      cpl_valid = 1'b0;
      @(negedge clk);
      chk(!err_stale && !err_timeout && !req_valid, "R11 idle completion ignored",
          {62'd0, err_stale, err_timeout}, 64'd0);
    end
    chk(rec_ready, "R5 ready when idle", 64'(rec_ready), 64'd1);
    rec_addr = a; rec_data = d; db_addr = da; db_value = dv; rec_valid = 1'b1;
    @(negedge clk);
    rec_valid = 1'b0;
    cfg_plain_wr = ~plain; cfg_verify = ~ver;
    chk(!rec_ready, "R5 busy not ready", 64'(rec_ready), 64'd0);
    wait_req();
    chk(req_type == exp_wr_type(plain), {wt, " record write type"}, 64'(req_type), 64'(exp_wr_type(plain)));
    chk(req_len == 8'd64 && req_addr == a && req_data == d, "R1 record write fields", 64'(req_addr), 64'(a));
    chk(!req_ns && !req_ro, "R6 attributes", {62'd0, req_ns, req_ro}, 64'd0);
    grant($urandom_range(0, 3));
    repeat ($urandom_range(0, 2)) begin
      chk(!req_valid, "R3 no doorbell before done", 64'(req_valid), 64'd0);
      @(negedge clk);
    end
    req_done = 1'b1;
    @(negedge clk);
    req_done = 1'b0;
    if (ver) begin
      wait_req();
      chk(req_type == 2'd2 && req_len == 8'd64 && req_addr == a, "R8 read-back request",
          64'(req_addr), 64'(a));
      chk(!req_ns && !req_ro, "R6 attributes on read", {62'd0, req_ns, req_ro}, 64'd0);
      grant($urandom_range(0, 2));
      for (int k = 1; k <= TO + 1; k++) begin
        if (mode != 2 && k == cpl_k) begin
          cpl_valid = 1'b1;
          cpl_data = (mode == 1) ? (d ^ DW'(1) << 100) : d;
          @(negedge clk);
          cpl_valid = 1'b0;
          break;
        end
        chk(!req_valid, "R8 no request while waiting", 64'(req_valid), 64'd0);
        if (mode == 2 && k == TO)
          chk(!err_timeout, "R10 not yet timed out", 64'(err_timeout), 64'd0);
        if (mode == 2 && k == TO + 1) begin
          chk(err_timeout && !err_stale, "R10 timeout flagged", 64'(err_timeout), 64'd1);
          break;
        end
        @(negedge clk);
      end
      if (mode != 2)
        chk(err_stale == (mode == 1), "R9 stale flag", 64'(err_stale), 64'(mode == 1));
      if (mode != 0) begin
        for (int i = 0; i < 10; i++) begin
          chk(!req_valid && !irq && !rec_ready, mode == 1 ? "R9 stopped" : "R10 stopped",
              {61'd0, req_valid, irq, rec_ready}, 64'd0);
          @(negedge clk);
        end
        chk(mode == 1 ? err_stale : err_timeout, mode == 1 ? "R9 sticky" : "R10 sticky",
            64'(mode == 1 ? err_stale : err_timeout), 64'd1);
        errored = 1'b1;
        return;
      end
    end
    wait_req();
    chk(req_type == exp_wr_type(plain), {wt, " doorbell type"}, 64'(req_type), 64'(exp_wr_type(plain)));
    chk(req_len == 8'd4 && req_addr == da, "R3 doorbell address/length", 64'(req_addr), 64'(da));
    chk(req_data == exp_db_data(dv), "R3 doorbell data", req_data[63:0], 64'(dv));
    chk(!req_ns && !req_ro, "R6 attributes on doorbell", {62'd0, req_ns, req_ro}, 64'd0);
    grant($urandom_range(0, 3));
    repeat ($urandom_range(0, 2)) @(negedge clk);
    req_done = 1'b1;
    chk(!irq, "R4 irq low before doorbell done", 64'(irq), 64'd0);
    @(negedge clk);
    req_done = 1'b0;
    chk(irq, "R4 irq raised", 64'(irq), 64'd1);
    rec_valid = 1'b1; rec_addr = rand_addr(1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(irq && !rec_ready && !req_valid, "R5 record refused while irq pending",
          {62'd0, rec_ready, req_valid}, 64'd0);
    end
    rec_valid = 1'b0;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(!irq && rec_ready, "R4 irq cleared", 64'(irq), 64'd0);
  endtask

  initial begin
    bit e;
    void'($urandom(32'd20240611));
    do_reset();
    run_record(1'b0, 1'b0, 0, 1, 1'b0, e);
    run_record(1'b0, 1'b1, 0, 1, 1'b1, e);
    run_record(1'b1, 1'b0, 0, 1, 1'b1, e);
    run_record(1'b1, 1'b1, 0, TO, 1'b0, e);
    run_record(1'b1, 1'b0, 1, 3, 1'b0, e);
    if (e) do_reset();
    run_record(1'b1, 1'b0, 2, 0, 1'b0, e);
    if (e) do_reset();
    for (int n = 0; n < 40; n++) begin
      run_record(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0,
                 $urandom_range(1, TO), 1'($urandom_range(0, 1)), e);
      if (e) do_reset();
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule